// File: doc/BRIEF.md
# Streaming Byte String Comparator

This block compares two byte strings sixteen bytes per step. The strings may be ended by a zero byte, or they may be buffers of a given byte count. Each string arrives on its own valid/ready stream as lane-aligned blocks. Byte 0 of the string sits in lane 0 of the first block. A block pair is consumed only when both streams offer data, so the two strings always advance together.

Each lane has an equality comparator on the byte pair and a zero detector on the first operand's byte. Their results are merged into a per-lane stop mask. The lowest stop lane ends the compare. The block then pulses `done` and reports two results: the global byte index where the compare stopped, and a two-bit ordering of the first string against the second. These results stay valid until the next compare is started. Fetching the strings from memory and shifting them into lane alignment is left to the surrounding logic.

Top module: `strcmp_stream`

## Requirements
- R1: After reset `done` is 0 and both `a_ready` and `b_ready` are 0.
- R2: A ready output is high only while a compare is running, `start` is low and the other stream's valid is high, so that `a_valid && a_ready` always equals `b_valid && b_ready`.
- R3: In terminator mode (`len_mode`=0) lane i of a block stops the compare when its two bytes differ or when the first string's byte is 0x00. The reported index is 16 × (number of blocks consumed before this one) + the lowest stop lane.
- R4: A block pair with no stop lane produces no `done`, and the block keeps accepting further block pairs.
- R5: `order` is the unsigned compare of the two bytes at the stop lane: 2'b01 when the first string's byte is greater, 2'b11 when it is less, 2'b00 when the bytes are equal. A terminator in the first string facing a nonzero byte therefore gives 2'b11.
- R6: In length mode (`len_mode`=1) with byte count L, every byte at global position ≥ L is a stop position and reports order 2'b00 whatever its contents. Zero bytes never stop the compare. Two buffers that agree on their first L bytes report index L.
- R7: In length mode, a byte mismatch at a global position below L stops the compare at that position, with the order given by R5.
- R8: `done` is high for exactly one cycle. After it, both ready outputs stay 0 and `stop_index`/`order` hold their values until the next `start`.
- R9: `start` (sampled at a clock edge) begins a new compare from block 0 with the mode and length given with it. This also aborts a compare that is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a new compare |
| len_mode | input | 1 | 0: zero-terminated strings, 1: explicit byte count |
| length | input | BLK_W+log2(LANES) | Byte count for length mode, sampled with `start` |
| a_valid | input | 1 | First string block valid |
| a_data | input | 8×LANES | First string block, lane i in bits [8i+7:8i] |
| a_ready | output | 1 | First string block accepted |
| b_valid | input | 1 | Second string block valid |
| b_data | input | 8×LANES | Second string block, lane i in bits [8i+7:8i] |
| b_ready | output | 1 | Second string block accepted |
| done | output | 1 | One-cycle pulse when the compare has ended |
| stop_index | output | BLK_W+log2(LANES) | Global byte index where the compare stopped |
| order | output | 2 | 00 equal, 01 first greater, 11 first less |

## Verification
The bench uses the default LANES=16 and BLK_W=12, with a 16-bit length and index. This lets it place stops at both edge lanes (0 and 15) and carry a string across a block boundary so that the block count shows up in the index. It also exercises length mode with a limit that falls inside the second block, a zero length, and a mismatch lying just past the limit. Zero bytes inside a length-mode buffer check that terminator detection is really off in that mode.

// File: rtl/strcmp_pkg.sv
package strcmp_pkg;

  typedef enum logic [1:0] {
    ORD_EQ = 2'b00,
    ORD_GT = 2'b01,
    ORD_LT = 2'b11
  } cmp_order_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctl_state_e;

endpackage

// File: rtl/strcmp_lane_array.sv
module strcmp_lane_array #(
  parameter int LANES = 16
) (
  input  logic [8*LANES-1:0]       a_data,
  input  logic [8*LANES-1:0]       b_data,
  input  logic                     len_mode,
  input  logic [$clog2(LANES):0]   rem_clip,
  output logic [LANES-1:0]         stop_mask,
  output logic [LANES-1:0]         eq_mask,
  output logic [LANES-1:0]         gt_mask,
  output logic [LANES-1:0]         inlen_mask
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] a_byte;
    logic [7:0] b_byte;
    logic       a_zero;

    assign a_byte = a_data[8*i +: 8];
    assign b_byte = b_data[8*i +: 8];

    // pairwise equality and the zero detector (same compare, one side tied to zero)
    assign eq_mask[i]    = (a_byte == b_byte);
    assign a_zero        = (a_byte == 8'h00);
    assign gt_mask[i]    = (a_byte > b_byte);
    assign inlen_mask[i] = !len_mode || (i < int'(rem_clip));
    assign stop_mask[i]  = !inlen_mask[i] || !eq_mask[i] || (a_zero && !len_mode);
  end

endmodule

// File: rtl/strcmp_first_one.sv
module strcmp_first_one #(
  parameter int W = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/strcmp_stream.sv
module strcmp_stream
  import strcmp_pkg::*;
#(
  parameter int LANES = 16,
  parameter int BLK_W = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic                             len_mode,
  input  logic [BLK_W+$clog2(LANES)-1:0]   length,
  input  logic                             a_valid,
  input  logic [8*LANES-1:0]               a_data,
  output logic                             a_ready,
  input  logic                             b_valid,
  input  logic [8*LANES-1:0]               b_data,
  output logic                             b_ready,
  output logic                             done,
  output logic [BLK_W+$clog2(LANES)-1:0]   stop_index,
  output logic [1:0]                       order
);

  localparam int LANE_BITS = $clog2(LANES);
  localparam int LEN_W     = BLK_W + LANE_BITS;

  // reset synchronizer: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  // state
  ctl_state_e        state_q, state_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              lmode_q, lmode_d;
  logic              done_q, done_d;
  logic [LEN_W-1:0]  idx_q, idx_d;
  cmp_order_e        ord_q, ord_d;

  logic              running;
  logic              fire;
  logic              ctl_en;
  logic              res_en;
  logic [LANE_BITS:0] rem_clip;

  logic [LANES-1:0]  stop_mask, eq_mask, gt_mask, inlen_mask;
  logic              hit;
  logic [LANE_BITS-1:0] lane_idx;
  cmp_order_e        lane_order;

  assign running = (state_q == ST_RUN);
  assign a_ready = running && !start && b_valid;
  assign b_ready = running && !start && a_valid;
  assign fire    = running && !start && a_valid && b_valid;

  assign rem_clip = (rem_q >= LEN_W'(LANES)) ? (LANE_BITS+1)'(LANES)
                                             : rem_q[LANE_BITS:0];

  strcmp_lane_array #(.LANES(LANES)) u_lanes (
    .a_data     (a_data),
    .b_data     (b_data),
    .len_mode   (lmode_q),
    .rem_clip   (rem_clip),
    .stop_mask  (stop_mask),
    .eq_mask    (eq_mask),
    .gt_mask    (gt_mask),
    .inlen_mask (inlen_mask)
  );

  strcmp_first_one #(.W(LANES)) u_first (
    .vec (stop_mask),
    .any (hit),
    .idx (lane_idx)
  );

  always_comb begin
    if (!inlen_mask[lane_idx] || eq_mask[lane_idx]) lane_order = ORD_EQ;
    else if (gt_mask[lane_idx])                      lane_order = ORD_GT;
    else                                             lane_order = ORD_LT;
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    blk_d   = blk_q;
    rem_d   = rem_q;
    lmode_d = lmode_q;
    done_d  = 1'b0;
    idx_d   = idx_q;
    ord_d   = ord_q;
    if (start) begin
      state_d = ST_RUN;
      blk_d   = '0;
      rem_d   = length;
      lmode_d = len_mode;
    end else if (fire) begin
      if (hit) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        idx_d   = LEN_W'(blk_q) * LEN_W'(LANES) + LEN_W'(lane_idx);
        ord_d   = lane_order;
      end else begin
        blk_d = blk_q + 1'b1;
        if (lmode_q) rem_d = rem_q - LEN_W'(LANES);
      end
    end
  end

  assign ctl_en = start || fire;
  assign res_en = fire && hit && !start;

  // registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      blk_q   <= '0;
      rem_q   <= '0;
      lmode_q <= 1'b0;
    end else if (ctl_en) begin
      blk_q   <= blk_d;
      rem_q   <= rem_d;
      lmode_q <= lmode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      idx_q <= '0;
      ord_q <= ORD_EQ;
    end else if (res_en) begin
      idx_q <= idx_d;
      ord_q <= ord_d;
    end
  end

  assign done       = done_q;
  assign stop_index = idx_q;
  assign order      = ord_q;

endmodule

// File: rtl/strcmp_stream_chk.sv
module strcmp_stream_chk #(
  parameter int LANES = 16,
  parameter int BLK_W = 12
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           start,
  input logic                           a_valid,
  input logic                           a_ready,
  input logic                           b_valid,
  input logic                           b_ready,
  input logic                           done,
  input logic [BLK_W+$clog2(LANES)-1:0] stop_index,
  input logic [1:0]                     order
);

  AST_READY_NEEDS_PEER: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ready |-> b_valid) and (b_ready |-> a_valid)); // R2

  AST_JOINT_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready) == (b_valid && b_ready)); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_NO_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !a_ready && !b_ready); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(stop_index) && $stable(order)); // R8

  AST_ORDER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    order != 2'b10); // R5

  AST_NO_READY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !a_ready && !b_ready); // R9

endmodule

bind strcmp_stream strcmp_stream_chk #(.LANES(LANES), .BLK_W(BLK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .a_valid    (a_valid),
  .a_ready    (a_ready),
  .b_valid    (b_valid),
  .b_ready    (b_ready),
  .done       (done),
  .stop_index (stop_index),
  .order      (order)
);

// File: tb/tb_strcmp_stream.sv
`timescale 1ns/1ps
module tb_strcmp_stream;

  localparam int LANES = 16;
  localparam int BLK_W = 12;
  localparam int IW    = BLK_W + 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic              len_mode;
  logic [IW-1:0]     length;
  logic              a_valid, b_valid;
  logic [127:0]      a_data, b_data;
  logic              a_ready, b_ready;
  logic              done;
  logic [IW-1:0]     stop_index;
  logic [1:0]        order;

  int checks   = 0;
  int failures = 0;

  always #4 clk = ~clk;

  strcmp_stream #(.LANES(LANES), .BLK_W(BLK_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_mode(len_mode), .length(length),
    .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
    .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready),
    .done(done), .stop_index(stop_index), .order(order)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input string s);
    logic [127:0] v = '0;
    for (int k = 0; k < 16; k++)
      if (k < s.len()) v[8*k +: 8] = s[k];
    return v;
  endfunction

  task automatic do_start(input bit mode, input int len);
    @(negedge clk);
    start = 1'b1; len_mode = mode; length = IW'(len);
    @(negedge clk);
    start = 1'b0;
  endtask

  // drive one block pair, wait for the transfer, sample one cycle later
  task automatic send_pair(input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    a_data = a; b_data = b; a_valid = 1'b1; b_valid = 1'b1;
    #1;
    while (!a_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    a_valid = 1'b0; b_valid = 1'b0;
  endtask

  task automatic expect_result(input string req, input int idx, input int ord);
    check(done == 1'b1, req, done, 1);
    check(int'(stop_index) == idx, req, stop_index, idx);
    check(int'(order) == ord, req, order, ord);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; len_mode = 1'b0; length = '0;
    a_valid = 1'b1; b_valid = 1'b1; a_data = '0; b_data = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", done, 0);
    check(a_ready == 1'b0 && b_ready == 1'b0, "R1", a_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(a_ready == 1'b0, "R2", a_ready, 0); // idle, valids high
    a_valid = 1'b0; b_valid = 1'b0;
  endtask

  task automatic t_term_equal;
    do_start(1'b0, 0);
    send_pair(mk("abc"), mk("abc"));
    expect_result("R3", 3, 0);
  endtask

  task automatic t_order_cases;
    do_start(1'b0, 0);
    send_pair(mk("abd"), mk("abc"));
    expect_result("R5", 2, 1);
    do_start(1'b0, 0);
    send_pair(mk("ab"), mk("abc"));
    expect_result("R5", 2, 3);
    do_start(1'b0, 0);
    send_pair(mk("q"), mk("z"));
    expect_result("R3", 0, 3);
  endtask

  task automatic t_only_one_valid;
    do_start(1'b0, 0);
    @(negedge clk);
    a_valid = 1'b1; a_data = mk("x");
    #1;
    check(a_ready == 1'b0, "R2", a_ready, 0);
    check(b_ready == 1'b1, "R2", b_ready, 1);
    a_valid = 1'b0;
    send_pair(mk("x"), mk("x"));
    expect_result("R3", 1, 0);
  endtask

  task automatic t_multiblock;
    logic [127:0] b2;
    do_start(1'b0, 0);
    send_pair(mk("ABCDEFGHIJKLMNOP"), mk("ABCDEFGHIJKLMNOP"));
    check(done == 1'b0, "R4", done, 0);
    send_pair(mk("ABCDEFGHIJKLMNOP"), mk("ABCDEFGHIJKLMNOP"));
    check(done == 1'b0, "R4", done, 0);
    b2 = mk("0123456789abcdeZ");
    send_pair(mk("0123456789abcdef"), b2);
    expect_result("R4", 47, 1);
  endtask

  task automatic t_done_pulse;
    int held;
    held = int'(stop_index);
    @(negedge clk);
    check(done == 1'b0, "R8", done, 0);
    a_valid = 1'b1; b_valid = 1'b1;
    #1;
    check(a_ready == 1'b0 && b_ready == 1'b0, "R8", a_ready, 0);
    repeat (3) @(negedge clk);
    check(int'(stop_index) == held, "R8", stop_index, held);
    a_valid = 1'b0; b_valid = 1'b0;
  endtask

  task automatic t_len_equal;
    do_start(1'b1, 20);
    send_pair('0, '0); // zero bytes must not stop in length mode
    check(done == 1'b0, "R6", done, 0);
    send_pair(mk("abcdXXXX"), mk("abcdYYYY"));
    expect_result("R6", 20, 0);
  endtask

  task automatic t_len_mismatch;
    do_start(1'b1, 20);
    send_pair(mk("ABCDEFGHIJKLMNOP"), mk("ABCDEFGHIJKLMNOP"));
    send_pair(mk("abc"), mk("abd"));
    expect_result("R7", 18, 3);
    do_start(1'b1, 0);
    send_pair(mk("a"), mk("b"));
    expect_result("R6", 0, 0);
    do_start(1'b1, 16);
    send_pair(mk("ABCDEFGHIJKLMNOP"), mk("ABCDEFGHIJKLMNOP"));
    check(done == 1'b0, "R6", done, 0);
    send_pair(mk("z"), mk("a"));
    expect_result("R6", 16, 0);
  endtask

  task automatic t_restart;
    do_start(1'b0, 0);
    send_pair(mk("ABCDEFGHIJKLMNOP"), mk("ABCDEFGHIJKLMNOP"));
    check(done == 1'b0, "R9", done, 0);
    do_start(1'b0, 0);
    send_pair(mk("kv"), mk("k"));
    expect_result("R9", 1, 1);
  endtask

  initial begin
    t_reset();
    t_term_equal();
    t_order_cases();
    t_only_one_valid();
    t_multiblock();
    t_done_pulse();
    t_len_equal();
    t_len_mismatch();
    t_restart();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule